// File: doc/BRIEF.md
# Translation-Control Register Access Arbiter

This block sits beside the system-register file of a processor core and handles every access aimed at one 64-bit translation-control register. The register can be reached through a main encoding and through an alias encoding. A request carries the five encoding fields, the direction, the current exception level and a set of hypervisor controls. The block resolves the request through a fixed-priority decision tree. The result is one of five outcomes: access the register itself, access the level-2 counterpart, redirect to a memory offset, trap to level 2 with a syndrome class, or undefined.

The block also holds the register. Writes that resolve to the register update the storage, and the reserved bit positions are forced to zero. Reads that resolve to the register return its current contents. The response is registered and appears one cycle after the request. A request whose encoding matches neither form produces no response and changes nothing.

Top module: `sysreg_trap_ctrl`

## Requirements
- R1: For a valid request with a matching encoding, `rsp_valid` is 1 in the cycle after the request, and `rsp_kind` holds one of these codes: 0 = register, 1 = level-2 counterpart, 2 = memory redirect, 3 = trap, 4 = undefined.
- R2: A request at level 0 (`req_el` = 0), through either encoding, is undefined (code 4).
- R3: At level 1 with the main encoding (op0=3, op1=0, CRn=2, CRm=0, op2=2) and `el2_en` set, the request traps (code 3, `rsp_ec` = 0x18) in two cases: a read while `trap_vm_rd` is set, or a write while `trap_vm_wr` is set.
- R4: At level 1 with the main encoding, if the R3 check does not trap, the request traps with class 0x18 when all of the following hold: `el2_en` is set, `fgt_impl` is set, `el3_present` is 0 or `el3_fgt_en` is 1, and the fine-grained bit for the request's direction (`fgt_rd` or `fgt_wr`) is set.
- R5: At level 1 with the main encoding and no trap from R3 or R4, `nv_ctl` = 3'b111 gives a memory redirect (code 2, `rsp_mem_off` = 0x120). Any other value accesses the register (code 0).
- R6: With the main encoding, a level-2 request gives code 1 when `host_mode` is set and code 0 otherwise. A level-3 request always gives code 0.
- R7: At level 1 with the alias encoding (op1=5, all other fields as in R3), the outcome depends on `nv_ctl`: 3'b101 gives a memory redirect to 0x120. Otherwise, if bit 0 is 1, the request traps with class 0x18. Otherwise the request is undefined.
- R8: At level 2 or level 3 with the alias encoding, the request gives code 0 when `host_mode` is set and code 4 otherwise.
- R9: A write with outcome 0 stores `req_wdata`, with bits 63, 62, 35 and 6 forced to zero. A read with outcome 0 returns the stored value in `rsp_rdata`. Every other outcome, and every write, returns `rsp_rdata` = 0.
- R10: A write whose outcome is not 0 leaves the stored value unchanged.
- R11: A request whose encoding matches neither form gives `rsp_valid` = 0 in the next cycle and leaves the stored value unchanged.
- R12: Reset clears the stored value to zero and drives `rsp_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Current exception level |
| req_wdata | input | DATA_W | Write data |
| el2_en | input | 1 | Level 2 is enabled |
| host_mode | input | 1 | Level 2 runs as host |
| trap_vm_rd | input | 1 | Trap reads of memory controls |
| trap_vm_wr | input | 1 | Trap writes of memory controls |
| fgt_impl | input | 1 | Fine-grained traps are implemented |
| el3_present | input | 1 | Level 3 exists |
| el3_fgt_en | input | 1 | Level 3 enables fine-grained traps |
| fgt_rd | input | 1 | Fine-grained read trap bit |
| fgt_wr | input | 1 | Fine-grained write trap bit |
| nv_ctl | input | 3 | Nested-virtualisation control |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 3 | Outcome code (R1) |
| rsp_ec | output | EC_W | Syndrome class on a trap, else 0 |
| rsp_mem_off | output | OFF_W | Memory offset on a redirect, else 0 |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The bench uses the default parameters: a 64-bit register with reserved bits at 63, 62, 35 and 6, trap class 0x18 and redirect offset 0x120. All-ones write data therefore shows directly whether the reserved positions are masked. The stimulus draws every hypervisor control independently and biases the encoding toward the two matching forms. This covers every branch of the priority tree: a virtual-memory trap masking a fine-grained trap, and a fine-grained trap masking a memory redirect. Blocked writes and non-matching writes are each followed by a level-3 read, so any leak into the storage shows up at the read-data port.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;

    typedef enum logic [2:0] {
        OUT_REG   = 3'd0,
        OUT_EL2   = 3'd1,
        OUT_MEM   = 3'd2,
        OUT_TRAP  = 3'd3,
        OUT_UNDEF = 3'd4
    } outcome_e;

    localparam logic [1:0] ENC_OP0       = 2'b11;
    localparam logic [2:0] ENC_OP1_MAIN  = 3'b000;
    localparam logic [2:0] ENC_OP1_ALIAS = 3'b101;
    localparam logic [3:0] ENC_CRN       = 4'b0010;
    localparam logic [3:0] ENC_CRM       = 4'b0000;
    localparam logic [2:0] ENC_OP2       = 3'b010;

    localparam logic [2:0] NV_MAIN_REDIR  = 3'b111;
    localparam logic [2:0] NV_ALIAS_REDIR = 3'b101;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } enc_t;

    typedef struct packed {
        logic       el2_en;
        logic       host;
        logic       trvm;
        logic       tvm;
        logic       fgt_impl;
        logic       el3_present;
        logic       el3_fgt_en;
        logic       fgt_rd;
        logic       fgt_wr;
        logic [2:0] nv;
    } hyp_t;

endpackage

// File: rtl/sysreg_access_decode.sv
module sysreg_access_decode
    import sysreg_trap_pkg::*;
(
    input  enc_t       enc,
    input  logic       is_write,
    input  logic [1:0] el,
    input  hyp_t       hyp,
    output logic       hit,
    output outcome_e   outcome
);

    logic is_alias;
    logic vm_trap;
    logic fg_trap;

    always_comb begin
        is_alias = (enc.op1 == ENC_OP1_ALIAS);
        hit = (enc.op0 == ENC_OP0) && (enc.crn == ENC_CRN) &&
              (enc.crm == ENC_CRM) && (enc.op2 == ENC_OP2) &&
              ((enc.op1 == ENC_OP1_MAIN) || is_alias);

        vm_trap = hyp.el2_en && (is_write ? hyp.tvm : hyp.trvm);
        fg_trap = hyp.el2_en && hyp.fgt_impl &&
                  (!hyp.el3_present || hyp.el3_fgt_en) &&
                  (is_write ? hyp.fgt_wr : hyp.fgt_rd);

        outcome = OUT_UNDEF;
        unique case (el)
            2'd0: outcome = OUT_UNDEF;
            2'd1: begin
                if (!is_alias) begin
                    if (vm_trap)                    outcome = OUT_TRAP;
                    else if (fg_trap)               outcome = OUT_TRAP;
                    else if (hyp.nv == NV_MAIN_REDIR) outcome = OUT_MEM;
                    else                            outcome = OUT_REG;
                end else begin
                    if (hyp.nv == NV_ALIAS_REDIR)   outcome = OUT_MEM;
                    else if (hyp.nv[0])             outcome = OUT_TRAP;
                    else                            outcome = OUT_UNDEF;
                end
            end
            2'd2: begin
                if (!is_alias) outcome = hyp.host ? OUT_EL2 : OUT_REG;
                else           outcome = hyp.host ? OUT_REG : OUT_UNDEF;
            end
            default: begin
                if (!is_alias) outcome = OUT_REG;
                else           outcome = hyp.host ? OUT_REG : OUT_UNDEF;
            end
        endcase
    end

endmodule

// File: rtl/sysreg_backing_store.sv
module sysreg_backing_store #(
    parameter int unsigned          DATA_W  = 64,
    parameter logic [DATA_W-1:0]    WR_MASK = 64'h3FFF_FFF7_FFFF_FFBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] value;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (we) store_d.value = wdata & WR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    assign rdata = store_q.value;

    // R10, R11: storage moves only on an enabled write
    a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(store_q.value));

endmodule

// File: rtl/sysreg_trap_ctrl.sv
module sysreg_trap_ctrl
    import sysreg_trap_pkg::*;
#(
    parameter int unsigned       DATA_W  = 64,
    parameter logic [DATA_W-1:0] WR_MASK = 64'h3FFF_FFF7_FFFF_FFBF,
    parameter int unsigned       EC_W    = 6,
    parameter logic [EC_W-1:0]   TRAP_EC = 6'h18,
    parameter int unsigned       OFF_W   = 12,
    parameter logic [OFF_W-1:0]  MEM_OFF = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic              req_write,
    input  logic [1:0]        req_el,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              el2_en,
    input  logic              host_mode,
    input  logic              trap_vm_rd,
    input  logic              trap_vm_wr,
    input  logic              fgt_impl,
    input  logic              el3_present,
    input  logic              el3_fgt_en,
    input  logic              fgt_rd,
    input  logic              fgt_wr,
    input  logic [2:0]        nv_ctl,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [EC_W-1:0]   rsp_ec,
    output logic [OFF_W-1:0]  rsp_mem_off,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic              valid;
        outcome_e          kind;
        logic [EC_W-1:0]   ec;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    enc_t              enc;
    hyp_t              hyp;
    logic              dec_hit;
    outcome_e          dec_outcome;
    logic              store_we;
    logic [DATA_W-1:0] store_val;
    rsp_t              rsp_d, rsp_q;

    assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
    assign hyp = '{el2_en: el2_en, host: host_mode, trvm: trap_vm_rd, tvm: trap_vm_wr,
                   fgt_impl: fgt_impl, el3_present: el3_present, el3_fgt_en: el3_fgt_en,
                   fgt_rd: fgt_rd, fgt_wr: fgt_wr, nv: nv_ctl};

    sysreg_access_decode u_decode (
        .enc      (enc),
        .is_write (req_write),
        .el       (req_el),
        .hyp      (hyp),
        .hit      (dec_hit),
        .outcome  (dec_outcome)
    );

    sysreg_backing_store #(
        .DATA_W  (DATA_W),
        .WR_MASK (WR_MASK)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .wdata (req_wdata),
        .rdata (store_val)
    );

    assign store_we = req_valid && dec_hit && req_write && (dec_outcome == OUT_REG);

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid && dec_hit;
        if (req_valid && dec_hit) begin
            rsp_d.kind = dec_outcome;
            if (dec_outcome == OUT_TRAP) rsp_d.ec  = TRAP_EC;
            if (dec_outcome == OUT_MEM)  rsp_d.off = MEM_OFF;
            if (dec_outcome == OUT_REG && !req_write) rsp_d.rdata = store_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_kind    = rsp_q.kind;
    assign rsp_ec      = rsp_q.ec;
    assign rsp_mem_off = rsp_q.off;
    assign rsp_rdata   = rsp_q.rdata;

    a_r1_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind <= 3'd4));

    a_r2_el0_undefined: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_hit && req_el == 2'd0) |=> (rsp_valid && rsp_kind == 3'd4));

    a_r3_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd3) |-> (rsp_ec == TRAP_EC));

    a_r5_redirect_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd2) |-> (rsp_mem_off == MEM_OFF));

    a_r6_el3_main_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_hit && req_el == 2'd3 && req_op1 == 3'b000) |=> (rsp_kind == 3'd0));

    a_r9_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != 3'd0) |-> (rsp_rdata == '0));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata & ~WR_MASK) == '0);

    a_r11_no_match_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dec_hit) |=> !rsp_valid);

endmodule

// File: tb/sysreg_trap_ctrl_bench.sv
module sysreg_trap_ctrl_bench;

    localparam logic [63:0] MASK = 64'h3FFF_FFF7_FFFF_FFBF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op0 = '0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_el = '0;
    logic [63:0] req_wdata = '0;
    logic        el2_en = 0, host_mode = 0, trap_vm_rd = 0, trap_vm_wr = 0;
    logic        fgt_impl = 0, el3_present = 0, el3_fgt_en = 0, fgt_rd = 0, fgt_wr = 0;
    logic [2:0]  nv_ctl = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_kind;
    logic [5:0]  rsp_ec;
    logic [11:0] rsp_mem_off;
    logic [63:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] model_store = '0;

    always #10 clk = ~clk;

    sysreg_trap_ctrl u_sysreg_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_write(req_write), .req_el(req_el), .req_wdata(req_wdata),
        .el2_en(el2_en), .host_mode(host_mode), .trap_vm_rd(trap_vm_rd), .trap_vm_wr(trap_vm_wr),
        .fgt_impl(fgt_impl), .el3_present(el3_present), .el3_fgt_en(el3_fgt_en),
        .fgt_rd(fgt_rd), .fgt_wr(fgt_wr), .nv_ctl(nv_ctl),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_ec(rsp_ec),
        .rsp_mem_off(rsp_mem_off), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference outcome from the requirements; hv = {el2_en,host,trvm,tvm,fgt_impl,el3_present,el3_fgt_en,fgt_rd,fgt_wr,nv[2:0]}
    function automatic void ref_model(input logic [1:0] op0, input logic [2:0] op1,
                                      input logic [3:0] crn, input logic [3:0] crm,
                                      input logic [2:0] op2, input logic wr, input logic [1:0] el,
                                      input logic [11:0] hv, output bit hit, output int kind,
                                      output string tag);
        bit alias_f = (op1 == 3'd5);
        bit vm = hv[11] && (wr ? hv[8] : hv[9]);
        bit fg = hv[11] && hv[7] && (!hv[6] || hv[5]) && (wr ? hv[3] : hv[4]);
        hit = (op0 == 2'd3) && (crn == 4'd2) && (crm == 4'd0) && (op2 == 3'd2) &&
              (op1 == 3'd0 || alias_f);
        kind = 4; tag = "R11";
        if (!hit) return;
        if (el == 2'd0) begin kind = 4; tag = "R2"; end
        else if (el == 2'd1 && !alias_f) begin
            if (vm)                   begin kind = 3; tag = "R3"; end
            else if (fg)              begin kind = 3; tag = "R4"; end
            else if (hv[2:0] == 3'd7) begin kind = 2; tag = "R5"; end
            else                      begin kind = 0; tag = "R5"; end
        end else if (el == 2'd1) begin
            tag = "R7";
            if (hv[2:0] == 3'd5) kind = 2;
            else if (hv[0])      kind = 3;
            else                 kind = 4;
        end else if (!alias_f) begin
            tag = "R6";
            kind = (el == 2'd2 && hv[10]) ? 1 : 0;
        end else begin
            tag = "R8";
            kind = hv[10] ? 0 : 4;
        end
    endfunction

    task automatic run_one(input logic [1:0] op0, input logic [2:0] op1, input logic [3:0] crn,
                           input logic [3:0] crm, input logic [2:0] op2, input logic wr,
                           input logic [1:0] el, input logic [11:0] hv, input logic [63:0] wd,
                           input string rtag);
        bit hit; int kind; string tag;
        logic [63:0] exp_rd;
        ref_model(op0, op1, crn, crm, op2, wr, el, hv, hit, kind, tag);
        exp_rd = (hit && kind == 0 && !wr) ? model_store : 64'h0;
        req_valid = 1'b1; req_op0 = op0; req_op1 = op1; req_crn = crn; req_crm = crm;
        req_op2 = op2; req_write = wr; req_el = el; req_wdata = wd;
        {el2_en, host_mode, trap_vm_rd, trap_vm_wr, fgt_impl, el3_present, el3_fgt_en,
         fgt_rd, fgt_wr, nv_ctl} = hv;
        @(negedge clk);
        check({tag, " R1 valid"}, {63'd0, rsp_valid}, {63'd0, hit});
        if (hit) begin
            check({tag, " R1 kind"}, {61'd0, rsp_kind}, 64'(kind));
            check({tag, " ec"}, {58'd0, rsp_ec}, (kind == 3) ? 64'h18 : 64'h0);
            check({tag, " off"}, {52'd0, rsp_mem_off}, (kind == 2) ? 64'h120 : 64'h0);
        end
        check({rtag, " rdata"}, rsp_rdata, exp_rd);
        if (hit && kind == 0 && wr) model_store = wd & MASK;
        req_valid = 1'b0;
    endtask

    task automatic read_el3(input string rtag);
        run_one(2'd3, 3'd0, 4'd2, 4'd0, 3'd2, 1'b0, 2'd3, 12'h000, 64'h0, rtag);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R12 valid after reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_el3("R12");

        // R9: all-ones write masks reserved bits, read back
        run_one(2'd3, 3'd0, 4'd2, 4'd0, 3'd2, 1'b1, 2'd3, 12'h000, {64{1'b1}}, "R9");
        read_el3("R9");
        // R10: trapped write (R3) leaves storage intact
        run_one(2'd3, 3'd0, 4'd2, 4'd0, 3'd2, 1'b1, 2'd1, 12'h900, 64'h0, "R10");
        read_el3("R10");
        // R10: redirected alias write at EL1
        run_one(2'd3, 3'd5, 4'd2, 4'd0, 3'd2, 1'b1, 2'd1, 12'h005, 64'h0, "R10");
        read_el3("R10");
        // R11: non-matching write
        run_one(2'd3, 3'd1, 4'd2, 4'd0, 3'd2, 1'b1, 2'd3, 12'h000, 64'h0, "R11");
        read_el3("R11");
        // R4: fine-grained, EL3 present but enabled; then disabled by EL3
        run_one(2'd3, 3'd0, 4'd2, 4'd0, 3'd2, 1'b0, 2'd1, 12'h8F0, 64'h0, "R4");
        run_one(2'd3, 3'd0, 4'd2, 4'd0, 3'd2, 1'b0, 2'd1, 12'h8D0, 64'h0, "R4");
        // R5 redirect, R6 host at EL2, R8 alias without host
        run_one(2'd3, 3'd0, 4'd2, 4'd0, 3'd2, 1'b0, 2'd1, 12'h007, 64'h0, "R5");
        run_one(2'd3, 3'd0, 4'd2, 4'd0, 3'd2, 1'b1, 2'd2, 12'h400, 64'h1, "R6");
        read_el3("R6");
        run_one(2'd3, 3'd5, 4'd2, 4'd0, 3'd2, 1'b0, 2'd3, 12'h000, 64'h0, "R8");
        run_one(2'd3, 3'd5, 4'd2, 4'd0, 3'd2, 1'b0, 2'd0, 12'h400, 64'h0, "R2");

        for (int i = 0; i < 4000; i++) begin
            logic [2:0] op1;
            logic [1:0] op0;
            logic [3:0] crn;
            int sel = $urandom_range(0, 9);
            op1 = (sel < 4) ? 3'd0 : (sel < 8) ? 3'd5 : 3'($urandom);
            op0 = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'd3;
            crn = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'd2;
            run_one(op0, op1, crn, 4'd0, 3'd2, 1'($urandom), 2'($urandom),
                    12'($urandom), {$urandom, $urandom}, "R9");
            if ($urandom_range(0, 7) == 0) read_el3("R10");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule